// File: doc/BRIEF.md
# Consecutive Reset-Symbol Detector

This block sits behind the symbol decoder of one serial link port. It watches the decoded control symbols and packet starts that the port receives. When a far-end device sends enough link-request/reset-device control symbols in an unbroken run, the block raises a request for a full device reset.

The run may contain status control symbols, which the block ignores. Any packet start, or any other control symbol, ends the run, and counting starts again from zero. The feature works only while the port's self-reset enable input is high. The request is a registered one-cycle pulse for the reset controller. That controller returns every state machine and configuration register to its power-on value, which is outside this block.

Symbol types come in on a `CODE_W`-bit code, qualified by a valid strobe. The run length and the code values are parameters.

Top module: `reset_symbol_detector`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rst_req` is 0. `rst` also clears any partial run, so a full run of reset symbols is needed after it.
- R2: With `self_rst_en` = 1, `RUN_LEN` (default 4) reset-device symbols in a row produce a request. A reset-device symbol is `sym_valid` = 1 with `sym_code` = `RESET_CODE` (default 3'b001). The request is `rst_req` = 1 in the cycle after the clock edge that accepts the last symbol of the run.
- R3: A run shorter than `RUN_LEN` produces no request. Cycles with `sym_valid` = 0 and `pkt_start` = 0 neither advance nor clear the run.
- R4: A status symbol (`sym_code` = `STATUS_CODE`, default 3'b010) between reset-device symbols neither advances nor clears the run.
- R5: A valid symbol with any code other than `RESET_CODE` or `STATUS_CODE` clears the run to zero.
- R6: `pkt_start` = 1 clears the run to zero. This holds even when a reset-device symbol is presented in the same cycle, and that symbol is then not counted.
- R7: While `self_rst_en` = 0, no request is produced and any partial run is cleared.
- R8: After a request, the run restarts from zero. A further `RUN_LEN` reset-device symbols are needed for the next request.
- R9: `rst_req` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | Decoded control symbol present this cycle |
| sym_code | input | CODE_W | Control symbol type code |
| pkt_start | input | 1 | Start of a received packet |
| self_rst_en | input | 1 | Per-port enable for reset by symbol run |
| rst_req | output | 1 | One-cycle device-reset request |

## Verification
The run count is internal, so the bench can observe a wrong count only through `rst_req`. A count that is too high or was not cleared shows up as a request arriving early. A count that was lost or cleared wrongly shows up as a request missing after the last symbol of a run. The result is visible one cycle after the edge that accepts that symbol. Each scenario therefore brings out the hidden count by completing a run and checking `rst_req` cycle by cycle, including the cycles where it must stay low.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
  // Per-cycle action that the classifier hands to the run counter
  typedef enum logic [1:0] {
    KIND_IDLE   = 2'd0,  // nothing that touches the run
    KIND_RESET  = 2'd1,  // advance the run
    KIND_STATUS = 2'd2,  // seen but ignored
    KIND_CLEAR  = 2'd3   // run broken
  } sym_kind_e;
endpackage

// File: rtl/rsd_classify.sv
module rsd_classify
  import rsd_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter logic [CODE_W-1:0] RESET_CODE  = 3'b001,
  parameter logic [CODE_W-1:0] STATUS_CODE = 3'b010
) (
  input  logic              sym_valid,
  input  logic [CODE_W-1:0] sym_code,
  input  logic              pkt_start,
  input  logic              enable,
  output sym_kind_e         kind
);
  always_comb begin
    if (!enable || pkt_start) begin
      kind = KIND_CLEAR;
    end else if (!sym_valid) begin
      kind = KIND_IDLE;
    end else if (sym_code == RESET_CODE) begin
      kind = KIND_RESET;
    end else if (sym_code == STATUS_CODE) begin
      kind = KIND_STATUS;
    end else begin
      kind = KIND_CLEAR;
    end
  end
endmodule

// File: rtl/rsd_run_counter.sv
module rsd_run_counter
  import rsd_pkg::*;
#(
  parameter int RUN_LEN = 4,
  localparam int CNT_W  = $clog2(RUN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  sym_kind_e        kind,
  output logic [CNT_W-1:0] count,
  output logic             run_done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

  assign run_done = (kind == KIND_RESET) && (count == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      unique case (kind)
        KIND_CLEAR: count <= '0;
        KIND_RESET: count <= run_done ? '0 : count + 1'b1;
        default:    count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rsd_pulse_reg.sv
module rsd_pulse_reg (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse
);
  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= fire;
  end
endmodule

// File: rtl/reset_symbol_detector.sv
module reset_symbol_detector
  import rsd_pkg::*;
#(
  parameter int RUN_LEN = 4,
  parameter int CODE_W  = 3,
  parameter logic [CODE_W-1:0] RESET_CODE  = 3'b001,
  parameter logic [CODE_W-1:0] STATUS_CODE = 3'b010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sym_valid,
  input  logic [CODE_W-1:0] sym_code,
  input  logic              pkt_start,
  input  logic              self_rst_en,
  output logic              rst_req
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);

  sym_kind_e        kind;
  logic [CNT_W-1:0] run_count;
  logic             run_done;

  rsd_classify #(
    .CODE_W(CODE_W), .RESET_CODE(RESET_CODE), .STATUS_CODE(STATUS_CODE)
  ) u_classify (
    .sym_valid(sym_valid), .sym_code(sym_code), .pkt_start(pkt_start),
    .enable(self_rst_en), .kind(kind)
  );

  rsd_run_counter #(.RUN_LEN(RUN_LEN)) u_count (
    .clk(clk), .rst(rst), .kind(kind), .count(run_count), .run_done(run_done)
  );

  rsd_pulse_reg u_pulse (
    .clk(clk), .rst(rst), .fire(run_done), .pulse(rst_req)
  );
endmodule

// File: rtl/rsd_checker.sv
module rsd_checker #(
  parameter int CODE_W = 3,
  parameter int CNT_W  = 3,
  parameter logic [CODE_W-1:0] RESET_CODE  = 3'b001,
  parameter logic [CODE_W-1:0] STATUS_CODE = 3'b010
) (
  input logic              clk,
  input logic              rst,
  input logic              sym_valid,
  input logic [CODE_W-1:0] sym_code,
  input logic              pkt_start,
  input logic              self_rst_en,
  input logic              rst_req,
  input logic [CNT_W-1:0]  run_count
);
  // R1: no request in the cycle right after reset is released
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rst_req);

  // R2: a request follows an accepted reset-device symbol
  a_r2_caused_by_reset_sym: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(sym_valid && sym_code == RESET_CODE));

  // R4: a lone status symbol leaves the run untouched
  a_r4_status_hold: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && sym_code == STATUS_CODE && !pkt_start && self_rst_en)
      |=> $stable(run_count));

  // R6: packet start empties the run and blocks a request
  a_r6_pkt_clears: assert property (@(posedge clk) disable iff (rst)
    pkt_start |=> (run_count == '0 && !rst_req));

  // R7: disabled port never requests and holds no run
  a_r7_enable_gate: assert property (@(posedge clk) disable iff (rst)
    !self_rst_en |=> (run_count == '0 && !rst_req));

  // R9: request lasts one cycle
  a_r9_single_cycle: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
endmodule

bind reset_symbol_detector rsd_checker #(
  .CODE_W(CODE_W), .CNT_W(CNT_W), .RESET_CODE(RESET_CODE), .STATUS_CODE(STATUS_CODE)
) u_rsd_checker (
  .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_code(sym_code),
  .pkt_start(pkt_start), .self_rst_en(self_rst_en), .rst_req(rst_req),
  .run_count(run_count)
);

// File: tb/reset_symbol_detector_test.sv
`timescale 1ns/1ps
module reset_symbol_detector_test;
  localparam logic [2:0] C_RST = 3'b001;
  localparam logic [2:0] C_STS = 3'b010;
  localparam logic [2:0] C_OTH = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sym_valid = 1'b0;
  logic [2:0] sym_code = '0;
  logic pkt_start = 1'b0;
  logic en = 1'b1;
  logic rst_req;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  reset_symbol_detector uut (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_code(sym_code),
    .pkt_start(pkt_start), .self_rst_en(en), .rst_req(rst_req)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rst_req=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle of input, then observe rst_req after the edge
  task automatic step(input logic v, input logic [2:0] c, input logic p,
                      input logic e, input string tag, input logic exp);
    sym_valid = v; sym_code = c; pkt_start = p; en = e;
    @(posedge clk);
    @(negedge clk);
    check(tag, rst_req, exp);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 3'b000, 1'b0, 1'b1, tag, 1'b0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    sym_valid = 1'b0; pkt_start = 1'b0; en = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 after reset", rst_req, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b1, C_RST, 1'b0, 1'b1, "R3 partial", 1'b0);
    do_reset();
    step(1'b1, C_RST, 1'b0, 1'b1, "R1 reset cleared run", 1'b0);
    for (int i = 0; i < 2; i++) step(1'b1, C_RST, 1'b0, 1'b1, "R1 rebuild", 1'b0);
    step(1'b1, C_RST, 1'b0, 1'b1, "R1 full run after reset", 1'b1);
    idle("R9 after pulse");
  endtask

  task automatic t_basic();
    do_reset();
    for (int i = 0; i < 3; i++) step(1'b1, C_RST, 1'b0, 1'b1, "R3 short run", 1'b0);
    step(1'b1, C_RST, 1'b0, 1'b1, "R2 fourth symbol", 1'b1);
    idle("R9 one cycle");
    idle("R9 stays low");
  endtask

  task automatic t_idle_gap();
    do_reset();
    step(1'b1, C_RST, 1'b0, 1'b1, "R3 gap", 1'b0);
    step(1'b1, C_RST, 1'b0, 1'b1, "R3 gap", 1'b0);
    for (int i = 0; i < 3; i++) idle("R3 idle");
    step(1'b1, C_RST, 1'b0, 1'b1, "R3 gap", 1'b0);
    step(1'b1, C_RST, 1'b0, 1'b1, "R3 idle kept run", 1'b1);
  endtask

  task automatic t_status();
    do_reset();
    step(1'b1, C_RST, 1'b0, 1'b1, "R4 seq", 1'b0);
    step(1'b1, C_STS, 1'b0, 1'b1, "R4 status no advance", 1'b0);
    step(1'b1, C_RST, 1'b0, 1'b1, "R4 seq", 1'b0);
    step(1'b1, C_STS, 1'b0, 1'b1, "R4 status no advance", 1'b0);
    step(1'b1, C_STS, 1'b0, 1'b1, "R4 status no advance", 1'b0);
    step(1'b1, C_RST, 1'b0, 1'b1, "R4 seq", 1'b0);
    step(1'b1, C_RST, 1'b0, 1'b1, "R4 status kept run", 1'b1);
  endtask

  task automatic t_other();
    do_reset();
    for (int i = 0; i < 3; i++) step(1'b1, C_RST, 1'b0, 1'b1, "R5 seq", 1'b0);
    step(1'b1, C_OTH, 1'b0, 1'b1, "R5 other symbol", 1'b0);
    for (int i = 0; i < 3; i++) step(1'b1, C_RST, 1'b0, 1'b1, "R5 run was cleared", 1'b0);
    step(1'b1, C_RST, 1'b0, 1'b1, "R5 new full run", 1'b1);
  endtask

  task automatic t_pkt();
    do_reset();
    for (int i = 0; i < 3; i++) step(1'b1, C_RST, 1'b0, 1'b1, "R6 seq", 1'b0);
    step(1'b1, C_RST, 1'b1, 1'b1, "R6 packet beats reset symbol", 1'b0);
    for (int i = 0; i < 3; i++) step(1'b1, C_RST, 1'b0, 1'b1, "R6 run was cleared", 1'b0);
    step(1'b1, C_RST, 1'b0, 1'b1, "R6 new full run", 1'b1);
  endtask

  task automatic t_enable();
    do_reset();
    for (int i = 0; i < 5; i++) step(1'b1, C_RST, 1'b0, 1'b0, "R7 disabled", 1'b0);
    for (int i = 0; i < 3; i++) step(1'b1, C_RST, 1'b0, 1'b1, "R7 seq", 1'b0);
    step(1'b0, 3'b000, 1'b0, 1'b0, "R7 disable clears", 1'b0);
    step(1'b1, C_RST, 1'b0, 1'b1, "R7 run was cleared", 1'b0);
    step(1'b1, C_RST, 1'b0, 1'b1, "R7 seq", 1'b0);
    step(1'b1, C_RST, 1'b0, 1'b1, "R7 seq", 1'b0);
    step(1'b1, C_RST, 1'b0, 1'b1, "R7 full run after enable", 1'b1);
  endtask

  task automatic t_restart();
    do_reset();
    for (int n = 0; n < 2; n++) begin
      for (int i = 0; i < 3; i++) step(1'b1, C_RST, 1'b0, 1'b1, "R8 restart", 1'b0);
      step(1'b1, C_RST, 1'b0, 1'b1, "R8 pulse each run", 1'b1);
    end
    step(1'b1, C_RST, 1'b0, 1'b1, "R9 no double pulse", 1'b0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_idle_gap();
    t_status();
    t_other();
    t_pkt();
    t_enable();
    t_restart();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule